// File: doc/BRIEF.md
# Power Mode and Measurement Scheduler

This block decides when a battery monitor controller runs its measurement, calculation and protection work, and which power mode it is in while doing so. A slow timebase tick drives two period counters. In normal mode a cycle strobe fires once per second. In sleep mode it fires once per programmable number of ticks. In shutdown mode all strobes and checks stop.

Sleep is entered when the host allows it and the signed sense-resistor reading has stayed quiet for a whole one-second cycle. Sleep is left when the reading's magnitude, of either sign, reaches one of four configured thresholds, or when a fault is flagged. Shutdown follows an explicit command and ends only at reset. Every mode change waits for a tick boundary, and the period counter restarts whenever the mode changes. Separately, the system-present pin (active low) is polled once per second, and the result is held on an output flag.

Top module: `pwr_sched`

## Requirements
- R1: In normal mode `cycle_strobe_o` is a one-cycle pulse. It rises in the clock cycle after every TICKS_PER_SEC-th tick counted from reset or from entry to normal mode, and it is low at all other times.
- R2: In sleep mode the strobe pulses in the cycle after every `sleep_period_i`-th tick counted from sleep entry.
- R3: At the tick that ends a normal period, the mode becomes sleep if `sleep_en_i` is high and no wake condition was seen during the whole period. Otherwise the block stays in normal mode. The strobe for that period is still issued.
- R4: `thr_sel_i` codes 00, 01, 10 and 11 select threshold slot 0, 1, 2 and 3 of `thr_cfg_i`, where slot k occupies bits [k*SENSE_W +: SENSE_W]. A wake condition exists when |`sense_i`| is greater than or equal to the selected slot, for both positive and negative readings.
- R5: A high `fault_i` is a wake condition, whatever the sense reading.
- R6: Modes change only at a tick. A wake condition or a shutdown command seen between ticks is held and acted on at the next tick.
- R7: A pulse on `shutdown_cmd_i` moves the block to shutdown at the next tick. Shutdown lasts until reset. While in shutdown, no strobe is issued, wake conditions are ignored and the present flag is frozen.
- R8: Outside shutdown, `present_n_i` is sampled on every TICKS_PER_SEC-th tick from reset, and `sys_present_o` becomes 1 when the sampled level was low and 0 when it was high.
- R9: After reset, `mode_o` is 00 (normal), and the strobe and present flag are 0. Mode codes: 00 normal, 01 sleep, 10 shutdown.
- R10: `sleep_o` is high exactly in mode 01, and `shutdown_o` is high exactly in mode 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase tick |
| sense_i | input | SENSE_W | Signed sense-resistor reading |
| fault_i | input | 1 | Fault flag, wakes from sleep |
| present_n_i | input | 1 | System-present pin, low means present |
| sleep_en_i | input | 1 | Allows entry to sleep |
| shutdown_cmd_i | input | 1 | Request for shutdown |
| thr_sel_i | input | 2 | Wake threshold select code |
| thr_cfg_i | input | 4*SENSE_W | Four threshold slots in ADC counts |
| sleep_period_i | input | SLEEP_W | Sleep strobe interval in ticks |
| cycle_strobe_o | output | 1 | Measurement cycle strobe |
| sys_present_o | output | 1 | Polled system-present flag |
| mode_o | output | 2 | Current mode code |
| sleep_o | output | 1 | Sleep mode active |
| shutdown_o | output | 1 | Shutdown mode active |

## Verification
The bench builds the block with TICKS_PER_SEC = 4, SENSE_W = 16 and SLEEP_W = 4, and uses a sleep interval of 3 ticks. With these values a one-second period lasts only a few ticks, and it differs from the sleep interval. The test can therefore reach many normal and sleep periods, back-and-forth mode changes and the present-poll boundary. It also shows that the present poll keeps its own phase after a counter restart. Threshold slots of 10, 22, 45 and 90 counts let readings one count below and exactly at a threshold be tried for both signs.

// File: rtl/pm_sched_pkg.sv
// Shared types for the power mode scheduler.
// Assumes: mode codes are visible at the top level and are fixed as listed.
package pm_sched_pkg;
    typedef enum logic [1:0] {
        PM_NORMAL   = 2'b00,
        PM_SLEEP    = 2'b01,
        PM_SHUTDOWN = 2'b10
    } pm_mode_e;

    localparam int unsigned PM_THR_SLOTS = 4;
endpackage

// File: rtl/pm_tick_counter.sv
// Counts timebase ticks and reports the tick that completes a period.
// Assumes: limit_i >= 1. A restart has priority over counting.
module pm_tick_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             at_end_o
);
    logic [CNT_W-1:0] cnt_q;

    // Flag the tick that completes the current period.
    assign at_end_o = run_i && tick_i && (cnt_q == limit_i - CNT_W'(1));

    // Advance on each tick, wrap at period end, clear on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i || at_end_o) begin
            cnt_q <= '0;
        end else if (run_i && tick_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/pm_wake_cmp.sv
// Flags a wake condition: the magnitude of the signed sense reading is at or
// above the selected threshold slot, or a fault is raised.
// Assumes: threshold slots hold non-negative counts.
module pm_wake_cmp #(
    parameter int SENSE_W = 16
) (
    input  logic signed [SENSE_W-1:0]                           sense_i,
    input  logic        [pm_sched_pkg::PM_THR_SLOTS*SENSE_W-1:0] thr_cfg_i,
    input  logic        [1:0]                                   thr_sel_i,
    input  logic                                                fault_i,
    output logic                                                active_o
);
    logic [SENSE_W-1:0] slot [pm_sched_pkg::PM_THR_SLOTS];
    logic [SENSE_W:0]   ext;
    logic [SENSE_W:0]   mag;

    // Split the packed configuration into threshold slots.
    for (genvar k = 0; k < pm_sched_pkg::PM_THR_SLOTS; k++) begin : g_slot
        assign slot[k] = thr_cfg_i[k*SENSE_W +: SENSE_W];
    end

    // Form the magnitude one bit wider, so the most negative code cannot wrap.
    always_comb begin
        ext = {sense_i[SENSE_W-1], sense_i};
        mag = ext[SENSE_W] ? (~ext + (SENSE_W+1)'(1)) : ext;
    end

    // Compare against the selected slot and merge in the fault flag.
    assign active_o = fault_i || (mag >= {1'b0, slot[thr_sel_i]});
endmodule

// File: rtl/pm_mode_ctrl.sv
// Mode sequencer: normal, sleep and shutdown. Decisions are taken only at
// ticks; wake and shutdown requests are latched until then.
// Assumes: period_end_i is a tick qualified by the active period counter.
module pm_mode_ctrl (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_i,
    input  logic                   period_end_i,
    input  logic                   active_i,
    input  logic                   sleep_en_i,
    input  logic                   shutdown_cmd_i,
    output pm_sched_pkg::pm_mode_e mode_o,
    output logic                   mode_change_o
);
    import pm_sched_pkg::*;

    pm_mode_e mode_q, next_mode;
    logic     quiet_q, wake_pend_q, sd_pend_q;
    logic     sd_req, wake_req;

    // Choose the next mode from latched and current requests.
    always_comb begin
        sd_req    = sd_pend_q || shutdown_cmd_i;
        wake_req  = wake_pend_q || active_i;
        next_mode = mode_q;
        case (mode_q)
            PM_NORMAL: begin
                if (tick_i) begin
                    if (sd_req)
                        next_mode = PM_SHUTDOWN;
                    else if (period_end_i && sleep_en_i && quiet_q && !active_i)
                        next_mode = PM_SLEEP;
                end
            end
            PM_SLEEP: begin
                if (tick_i) begin
                    if (sd_req)        next_mode = PM_SHUTDOWN;
                    else if (wake_req) next_mode = PM_NORMAL;
                end
            end
            default: next_mode = PM_SHUTDOWN;
        endcase
    end

    assign mode_change_o = (next_mode != mode_q);
    assign mode_o        = mode_q;

    // Hold the mode and the requests that wait for the next tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= PM_NORMAL;
            sd_pend_q   <= 1'b0;
            wake_pend_q <= 1'b0;
        end else begin
            mode_q      <= next_mode;
            sd_pend_q   <= sd_req && (next_mode != PM_SHUTDOWN);
            wake_pend_q <= (mode_q == PM_SLEEP) && (next_mode == PM_SLEEP) && wake_req;
        end
    end

    // Track whether the current normal period has stayed free of wake conditions.
    always_ff @(posedge clk) begin
        if (!rst_n)                           quiet_q <= 1'b1;
        else if (mode_change_o || period_end_i) quiet_q <= 1'b1;
        else if (active_i)                    quiet_q <= 1'b0;
    end
endmodule

// File: rtl/pwr_sched.sv
// Power mode and measurement scheduler top. It issues cycle strobes at a
// mode-dependent period, sequences the power modes and polls the
// system-present pin once per second.
// Assumes: tick_i is a single-cycle pulse; a sleep interval of zero acts as one.
module pwr_sched #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int SENSE_W       = 16,
    parameter int SLEEP_W       = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic signed [SENSE_W-1:0]  sense_i,
    input  logic                       fault_i,
    input  logic                       present_n_i,
    input  logic                       sleep_en_i,
    input  logic                       shutdown_cmd_i,
    input  logic [1:0]                 thr_sel_i,
    input  logic [4*SENSE_W-1:0]       thr_cfg_i,
    input  logic [SLEEP_W-1:0]         sleep_period_i,
    output logic                       cycle_strobe_o,
    output logic                       sys_present_o,
    output logic [1:0]                 mode_o,
    output logic                       sleep_o,
    output logic                       shutdown_o
);
    import pm_sched_pkg::*;

    localparam int SEC_W = $clog2(TICKS_PER_SEC + 1);
    localparam int CNT_W = (SEC_W > SLEEP_W) ? SEC_W : SLEEP_W;
    localparam logic [CNT_W-1:0] SEC_LIMIT = CNT_W'(TICKS_PER_SEC);

    pm_mode_e         mode;
    logic             mode_change, running, active;
    logic             period_end, sec_end;
    logic [CNT_W-1:0] period_limit;
    logic             strobe_q, present_q;

    // Pick the period length for the current mode.
    always_comb begin
        if (mode == PM_SLEEP)
            period_limit = (sleep_period_i == '0) ? CNT_W'(1) : CNT_W'(sleep_period_i);
        else
            period_limit = SEC_LIMIT;
    end

    assign running = (mode != PM_SHUTDOWN);

    pm_wake_cmp #(.SENSE_W(SENSE_W)) i_wake (
        .sense_i   (sense_i),
        .thr_cfg_i (thr_cfg_i),
        .thr_sel_i (thr_sel_i),
        .fault_i   (fault_i),
        .active_o  (active)
    );

    pm_tick_counter #(.CNT_W(CNT_W)) i_period (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .run_i     (running),
        .restart_i (mode_change),
        .limit_i   (period_limit),
        .at_end_o  (period_end)
    );

    pm_tick_counter #(.CNT_W(CNT_W)) i_second (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .run_i     (running),
        .restart_i (1'b0),
        .limit_i   (SEC_LIMIT),
        .at_end_o  (sec_end)
    );

    pm_mode_ctrl i_mode (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_i         (tick_i),
        .period_end_i   (period_end),
        .active_i       (active),
        .sleep_en_i     (sleep_en_i),
        .shutdown_cmd_i (shutdown_cmd_i),
        .mode_o         (mode),
        .mode_change_o  (mode_change)
    );

    // Register the cycle strobe and the once-per-second present sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q  <= 1'b0;
            present_q <= 1'b0;
        end else begin
            strobe_q <= period_end;
            if (sec_end) present_q <= !present_n_i;
        end
    end

    assign cycle_strobe_o = strobe_q;
    assign sys_present_o  = present_q;
    assign mode_o         = mode;
    assign sleep_o        = (mode == PM_SLEEP);
    assign shutdown_o     = (mode == PM_SHUTDOWN);
endmodule

// File: rtl/pwr_sched_checker.sv
// Temporal properties of the scheduler ports, bound to every pwr_sched instance.
module pwr_sched_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       cycle_strobe_o,
    input logic       sys_present_o,
    input logic [1:0] mode_o,
    input logic       sleep_o,
    input logic       shutdown_o
);
    // R1: a strobe only follows a tick.
    assert_strobe_after_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_strobe_o |-> $past(tick_i));

    // R6: the mode moves only on a tick edge.
    assert_mode_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_o) |-> $past(tick_i));

    // R7: shutdown is never left.
    assert_shutdown_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10) |=> (mode_o == 2'b10));

    // R7: once settled in shutdown, no strobe appears.
    assert_no_strobe_shutdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == 2'b10) && ($past(mode_o) == 2'b10)) |-> !cycle_strobe_o);

    // R8: the present flag moves only on a tick edge.
    assert_present_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sys_present_o) |-> $past(tick_i));

    // R10: the two mode flags are never high together.
    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sleep_o, shutdown_o}));
endmodule

bind pwr_sched pwr_sched_checker i_pwr_sched_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick_i         (tick_i),
    .cycle_strobe_o (cycle_strobe_o),
    .sys_present_o  (sys_present_o),
    .mode_o         (mode_o),
    .sleep_o        (sleep_o),
    .shutdown_o     (shutdown_o)
);

// File: tb/test_pwr_sched.sv
module test_pwr_sched;
    localparam int TPS = 4;
    localparam int SW  = 16;
    localparam int SLW = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               tick_i = 1'b0;
    logic signed [SW-1:0] sense_i = '0;
    logic               fault_i = 1'b0;
    logic               present_n_i = 1'b1;
    logic               sleep_en_i = 1'b0;
    logic               shutdown_cmd_i = 1'b0;
    logic [1:0]         thr_sel_i = 2'b00;
    logic [4*SW-1:0]    thr_cfg_i = {16'd90, 16'd45, 16'd22, 16'd10};
    logic [SLW-1:0]     sleep_period_i = 4'd3;
    logic               cycle_strobe_o, sys_present_o, sleep_o, shutdown_o;
    logic [1:0]         mode_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic       strobe;
        logic [1:0] mode;
        logic       pres;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    pwr_sched #(.TICKS_PER_SEC(TPS), .SENSE_W(SW), .SLEEP_W(SLW)) i_pwr_sched (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sense_i(sense_i),
        .fault_i(fault_i), .present_n_i(present_n_i), .sleep_en_i(sleep_en_i),
        .shutdown_cmd_i(shutdown_cmd_i), .thr_sel_i(thr_sel_i), .thr_cfg_i(thr_cfg_i),
        .sleep_period_i(sleep_period_i), .cycle_strobe_o(cycle_strobe_o),
        .sys_present_o(sys_present_o), .mode_o(mode_o), .sleep_o(sleep_o),
        .shutdown_o(shutdown_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: one tick pulse plus the expected result of that tick.
    task automatic tick_expect(input logic s, input logic [1:0] m, input logic p, input string req);
        exp_t e;
        @(negedge clk);
        tick_i = 1'b1;
        e.strobe = s; e.mode = m; e.pres = p; e.req = req;
        sb.push_back(e);
        @(negedge clk);
        tick_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_cycle();
        @(negedge clk);
    endtask

    // Monitor: compares outputs shortly after each edge.
    always @(posedge clk) begin
        exp_t e;
        if (rst_n && !done) begin
            if (tick_i && sb.size() > 0) begin
                e = sb.pop_front();
                #2;
                check(cycle_strobe_o == e.strobe, {e.req, " strobe"}, cycle_strobe_o, e.strobe);
                check(mode_o == e.mode, {e.req, " mode"}, mode_o, e.mode);
                check(sys_present_o == e.pres, {e.req, " R8 present"}, sys_present_o, e.pres);
                check(sleep_o == (e.mode == 2'b01), "R10 sleep flag", sleep_o, e.mode == 2'b01);
                check(shutdown_o == (e.mode == 2'b10), "R10 shutdown flag", shutdown_o, e.mode == 2'b10);
            end else begin
                #2;
                check(cycle_strobe_o == 1'b0, "R1 idle strobe", cycle_strobe_o, 0);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mode_o == 2'b00, "R9 reset mode", mode_o, 0);
        check(cycle_strobe_o == 1'b0, "R9 reset strobe", cycle_strobe_o, 0);
        check(sys_present_o == 1'b0, "R9 reset present", sys_present_o, 0);
        check(!sleep_o && !shutdown_o, "R10 reset flags", {sleep_o, shutdown_o}, 0);

        // Normal period of four ticks, present sampled high.
        tick_expect(0, 2'b00, 0, "R1");
        tick_expect(0, 2'b00, 0, "R1");
        tick_expect(0, 2'b00, 0, "R1");
        tick_expect(1, 2'b00, 0, "R1");
        present_n_i = 1'b0;
        tick_expect(0, 2'b00, 0, "R8");
        tick_expect(0, 2'b00, 0, "R8");
        tick_expect(0, 2'b00, 0, "R8");
        tick_expect(1, 2'b00, 1, "R8");

        // Quiet period with sleep allowed: enter sleep at the period end.
        sleep_en_i = 1'b1; sense_i = 16'sd5;
        tick_expect(0, 2'b00, 1, "R3");
        tick_expect(0, 2'b00, 1, "R3");
        tick_expect(0, 2'b00, 1, "R3");
        tick_expect(1, 2'b01, 1, "R3");
        tick_expect(0, 2'b01, 1, "R2");
        tick_expect(0, 2'b01, 1, "R2");
        tick_expect(1, 2'b01, 1, "R2");
        present_n_i = 1'b1;
        tick_expect(0, 2'b01, 0, "R8 sleep poll");
        tick_expect(0, 2'b01, 0, "R2");
        tick_expect(1, 2'b01, 0, "R2");

        // Negative reading one below, then at, the slot-1 threshold.
        thr_sel_i = 2'b01; sense_i = -16'sd21;
        tick_expect(0, 2'b01, 0, "R4 below");
        sense_i = -16'sd22;
        pulse_cycle();
        sense_i = '0;
        pulse_cycle();
        check(mode_o == 2'b01, "R6 held until tick", mode_o, 1);
        tick_expect(0, 2'b00, 0, "R6 R4 negative wake");

        // A busy normal period blocks sleep; the next quiet one enters it.
        sense_i = 16'sd30;
        pulse_cycle();
        sense_i = '0;
        tick_expect(0, 2'b00, 0, "R3");
        tick_expect(0, 2'b00, 0, "R3");
        tick_expect(0, 2'b00, 0, "R3");
        tick_expect(1, 2'b00, 0, "R3 busy stays normal");
        tick_expect(0, 2'b00, 0, "R3");
        tick_expect(0, 2'b00, 0, "R3");
        tick_expect(0, 2'b00, 0, "R3");
        tick_expect(1, 2'b01, 0, "R3 quiet enters sleep");

        // Positive reading against slot 3.
        thr_sel_i = 2'b11; sense_i = 16'sd89;
        tick_expect(0, 2'b01, 0, "R4 below slot3");
        sense_i = 16'sd90;
        pulse_cycle();
        sense_i = '0;
        tick_expect(0, 2'b00, 0, "R4 positive wake");
        tick_expect(0, 2'b00, 0, "R1");
        tick_expect(0, 2'b00, 0, "R1");
        tick_expect(0, 2'b00, 0, "R1");
        tick_expect(1, 2'b01, 0, "R1 R3");

        // Fault wake.
        tick_expect(0, 2'b01, 0, "R2");
        fault_i = 1'b1;
        pulse_cycle();
        fault_i = 1'b0;
        tick_expect(0, 2'b00, 0, "R5 fault wake");

        // Shutdown command waits for the tick, then everything stops.
        sleep_en_i = 1'b0;
        shutdown_cmd_i = 1'b1;
        pulse_cycle();
        shutdown_cmd_i = 1'b0;
        pulse_cycle();
        check(mode_o == 2'b00, "R6 shutdown waits for tick", mode_o, 0);
        tick_expect(0, 2'b10, 0, "R7 enter");
        present_n_i = 1'b0; sense_i = 16'sd200; fault_i = 1'b1;
        for (int i = 0; i < 8; i++) tick_expect(0, 2'b10, 0, "R7 frozen");

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R1 scoreboard drained", sb.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule